// File: doc/BRIEF.md
# Nibble-Bus Register Interface

This block is the processor-facing front end of a real-time clock. It sits on a narrow 4-bit bus that has a 4-bit address, two chip selects of opposite polarity, active-low read and write strobes and an optional address latch enable. It holds the thirteen time-digit registers and the three control registers that the timekeeping core reads.

All bus inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer. Strobe edges are then detected in the clock domain. Each register bit follows its own access rule:

- Some bits are read/write.
- Bits that do not exist are dropped on write and read back as zero.
- The busy bit is read-only.
- The interrupt flag is set by the core and can only be cleared by the bus.
- The adjust request is set by the bus and cleared by the core.
- The hour-format bit can only be written while the divider reset bit is already set.

The bidirectional data bus is modelled as separate input, output and output-enable signals.

Top module: `nbus_regif`

## Requirements
- R1: Addresses 0 to 12 select thirteen digit registers in this order: seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens, day units, day tens, month units, month tens, year units, year tens, weekday. A value written to one of them reads back from the same address.
- R2: Digit bits that do not exist are dropped on write and read as 0. The widths are: seconds tens 3 bits, minutes tens 3, hours tens 3 (bit 2 is the PM flag, bits 1:0 are the tens), day tens 2, month tens 1, weekday 3. All other digits are 4 bits wide.
- R3: While the latch enable is 1 and the low-active select is 0, the effective address follows the address pins. When the latch enable is 0, the address last captured is held, even if the pins change.
- R4: A register is written only on the rising edge of the write strobe, and only while the high-active select is 1 and the low-active select is 0. A strobe given with the low-active select at 1 changes nothing.
- R5: While the read strobe is low and the chip is selected, the output enable is 1 and the addressed register value is on the data output. If both strobes are low together, the output enable stays 0.
- R6: While the high-active select is 0, the hold bit and the divider reset bit are forced to 0, and writes are ignored.
- R7: Control register at address 13 has these bits: bit 0 hold, bit 1 busy, bit 2 interrupt flag, bit 3 adjust. Bit 1 reads the busy input, and writes to it have no effect.
- R8: Bit 2 of address 13 is set by a pulse on the interrupt-set input. Writing 0 to it clears it. Writing 1 to it leaves it unchanged.
- R9: Control register at address 15 has these bits: bit 0 divider reset, bit 1 stop, bit 2 24-hour mode, bit 3 test. Bit 2 takes a written value only if the divider reset bit is already 1 before that write.
- R10: In 24-hour mode, the PM flag (bit 2 of the hours-tens register) reads as 0. When the block enters 12-hour mode, bit 1 of the hours-tens register is cleared, so it reads 0 until a 1 is written to it.
- R11: Writing 1 to bit 3 of address 13 sets the adjust request. A pulse on the adjust-done input clears it. Writing 0 to it has no effect.
- R12: Control register at address 14 has these bits: bit 0 mask, bit 1 interrupt mode, bits 3:2 period select. Its fields appear on the matching outputs and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Low-active chip select |
| sel_hi | input | 1 | High-active chip select |
| ale | input | 1 | Address latch enable |
| addr_in | input | 4 | Address pins |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 4 | Data bus input |
| dout | output | 4 | Data bus output |
| doe | output | 1 | Data bus output enable |
| busy_i | input | 1 | Busy status from the core |
| irq_set_i | input | 1 | Interrupt event pulse from the core |
| adj_done_i | input | 1 | Adjust-complete pulse from the core |
| hold_o | output | 1 | Hold bit |
| rest_o | output | 1 | Divider reset bit |
| stop_o | output | 1 | Stop bit |
| mode24_o | output | 1 | 24-hour mode |
| test_o | output | 1 | Test bit |
| mask_o | output | 1 | Interrupt output mask |
| irq_mode_o | output | 1 | Interrupt/standard-pulse mode |
| tsel_o | output | 2 | Period select |
| adj_o | output | 1 | Adjust request |
| irq_o | output | 1 | Interrupt flag |

## Verification
A digit register captured under the wrong address or mask shows up at the data output on the first read of that address. Because of the synchronizer, that read can come no earlier than four clocks after the write. A broken strobe edge detector or chip-select gate is different: it leaves a register unchanged, or changes one that should have kept its value. This is seen on a later read-back, or at once on the hold, reset and mode outputs. A control bit that breaks its access rule (busy, interrupt flag, adjust request, hour format) shows up on the next read of its control register or on its dedicated output, within a few clocks of the write or pulse that exposes it.

// File: rtl/nbus_pkg.sv
package nbus_pkg;
  localparam int NIB   = 4;
  localparam int ADRW  = 4;
  localparam int NDIG  = 13;
  localparam int IDX_H10 = 5;
  localparam logic [ADRW-1:0] A_CTLD = 4'd13;
  localparam logic [ADRW-1:0] A_CTLE = 4'd14;
  localparam logic [ADRW-1:0] A_CTLF = 4'd15;

  // Width mask of each digit register
  function automatic logic [NIB-1:0] digit_mask(input int idx);
    case (idx)
      1, 3, 5, 12: digit_mask = 4'b0111;
      7:           digit_mask = 4'b0011;
      9:           digit_mask = 4'b0001;
      default:     digit_mask = 4'b1111;
    endcase
  endfunction

  // Hours-tens read view: PM flag hidden in 24-hour mode
  function automatic logic [NIB-1:0] h10_view(input logic [NIB-1:0] v, input logic m24);
    h10_view = m24 ? (v & 4'b0011) : v;
  endfunction
endpackage

// File: rtl/nbus_sync.sv
module nbus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= INIT;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= INIT;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nbus_addr_latch.sv
module nbus_addr_latch #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale_s,
  input  logic          sel_n_s,
  input  logic [AW-1:0] addr_s,
  output logic [AW-1:0] eff_addr
);
  logic [AW-1:0] lat_q;
  logic          open_w;

  assign open_w = ale_s && !sel_n_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      lat_q <= '0;
    else if (open_w) lat_q <= addr_s;

  assign eff_addr = open_w ? addr_s : lat_q;

  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !open_w |=> $stable(lat_q)); // R3
endmodule

// File: rtl/nbus_digit_regs.sv
module nbus_digit_regs
  import nbus_pkg::*;
#(
  parameter int N  = NDIG,
  parameter int AW = ADRW,
  parameter int DW = NIB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          mode24,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] dig [N];
  logic          m24_prev;
  logic          enter12;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) m24_prev <= 1'b0;
    else        m24_prev <= mode24;

  assign enter12 = m24_prev && !mode24;

  generate
    for (genvar i = 0; i < N; i++) begin : g_dig
      if (i == IDX_H10) begin : g_h10
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) dig[i] <= '0;
          else if (wr_en && addr == AW'(i)) dig[i] <= wdata & digit_mask(i);
          else if (enter12) dig[i] <= dig[i] & 4'b1101;
      end else begin : g_plain
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) dig[i] <= '0;
          else if (wr_en && addr == AW'(i)) dig[i] <= wdata & digit_mask(i);
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (addr == AW'(i))
        rdata = (i == IDX_H10) ? h10_view(dig[i], mode24) : dig[i];
  end

  AST_DIGITS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !enter12) |=> $stable(dig[0]) && $stable(dig[N-1])); // R4
endmodule

// File: rtl/nbus_ctl_regs.sv
module nbus_ctl_regs
  import nbus_pkg::*;
#(
  parameter int DW = NIB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_hi_s,
  input  logic          wr_d,
  input  logic          wr_e,
  input  logic          wr_f,
  input  logic [DW-1:0] wdata,
  input  logic          busy_i,
  input  logic          irq_set_i,
  input  logic          adj_done_i,
  output logic [DW-1:0] reg_d,
  output logic [DW-1:0] reg_e,
  output logic [DW-1:0] reg_f,
  output logic          hold_o,
  output logic          rest_o,
  output logic          stop_o,
  output logic          mode24_o,
  output logic          test_o,
  output logic          mask_o,
  output logic          irq_mode_o,
  output logic [1:0]    tsel_o,
  output logic          adj_o,
  output logic          irq_o
);
  logic hold_q, irq_q, adj_q;
  logic rest_q, stop_q, m24_q, test_q;
  logic [DW-1:0] e_q;

  // Register D
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         hold_q <= 1'b0;
    else if (!sel_hi_s) hold_q <= 1'b0;
    else if (wr_d)      hold_q <= wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   irq_q <= 1'b0;
    else if (irq_set_i)           irq_q <= 1'b1;
    else if (wr_d && !wdata[2])   irq_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  adj_q <= 1'b0;
    else if (adj_done_i)         adj_q <= 1'b0;
    else if (wr_d && wdata[3])   adj_q <= 1'b1;

  // Register E
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    e_q <= '0;
    else if (wr_e) e_q <= wdata;

  // Register F
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         rest_q <= 1'b0;
    else if (!sel_hi_s) rest_q <= 1'b0;
    else if (wr_f)      rest_q <= wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stop_q <= 1'b0;
      test_q <= 1'b0;
      m24_q  <= 1'b0;
    end else if (wr_f) begin
      stop_q <= wdata[1];
      test_q <= wdata[3];
      if (rest_q) m24_q <= wdata[2];
    end

  assign reg_d      = {adj_q, irq_q, busy_i, hold_q};
  assign reg_e      = e_q;
  assign reg_f      = {test_q, m24_q, stop_q, rest_q};
  assign hold_o     = hold_q;
  assign rest_o     = rest_q;
  assign stop_o     = stop_q;
  assign mode24_o   = m24_q;
  assign test_o     = test_q;
  assign mask_o     = e_q[0];
  assign irq_mode_o = e_q[1];
  assign tsel_o     = e_q[3:2];
  assign adj_o      = adj_q;
  assign irq_o      = irq_q;

  AST_SEL_FORCES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hi_s |=> (!hold_q && !rest_q)); // R6
  AST_IRQ_ONLY_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(irq_set_i)); // R8
  AST_MODE_NEEDS_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (m24_q != $past(m24_q)) |-> $past(rest_q)); // R9
  AST_ADJ_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adj_q) |-> $past(wr_d && wdata[3])); // R11
endmodule

// File: rtl/nbus_regif.sv
module nbus_regif
  import nbus_pkg::*;
#(
  parameter int AW = ADRW,
  parameter int DW = NIB,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          sel_hi,
  input  logic          ale,
  input  logic [AW-1:0] addr_in,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          doe,
  input  logic          busy_i,
  input  logic          irq_set_i,
  input  logic          adj_done_i,
  output logic          hold_o,
  output logic          rest_o,
  output logic          stop_o,
  output logic          mode24_o,
  output logic          test_o,
  output logic          mask_o,
  output logic          irq_mode_o,
  output logic [1:0]    tsel_o,
  output logic          adj_o,
  output logic          irq_o
);
  localparam int DW2 = 2 + AW + DW;

  logic          rd_s, wr_s, sel_n_s, sel_hi_s, ale_s;
  logic [AW-1:0] addr_s, eff_addr;
  logic [DW-1:0] din_s;
  logic          wr_prev;
  logic          chip_on, wr_fire, rd_live;
  logic          wr_dig, wr_d, wr_e, wr_f;
  logic [DW-1:0] dig_rdata, reg_d, reg_e, reg_f, rdata;

  nbus_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b111)) u_sync_strb (
    .clk(clk), .rst_n(rst_n), .d({rd_n, wr_n, sel_n}), .q({rd_s, wr_s, sel_n_s}));

  nbus_sync #(.W(DW2), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d({sel_hi, ale, addr_in, din}),
    .q({sel_hi_s, ale_s, addr_s, din_s}));

  nbus_addr_latch #(.AW(AW)) u_alat (
    .clk(clk), .rst_n(rst_n), .ale_s(ale_s), .sel_n_s(sel_n_s),
    .addr_s(addr_s), .eff_addr(eff_addr));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wr_prev <= 1'b1;
    else        wr_prev <= wr_s;

  assign chip_on = sel_hi_s && !sel_n_s;
  assign wr_fire = chip_on && wr_s && !wr_prev;
  assign rd_live = chip_on && !rd_s && wr_s;

  assign wr_dig = wr_fire && (eff_addr < AW'(NDIG));
  assign wr_d   = wr_fire && (eff_addr == A_CTLD);
  assign wr_e   = wr_fire && (eff_addr == A_CTLE);
  assign wr_f   = wr_fire && (eff_addr == A_CTLF);

  nbus_digit_regs #(.N(NDIG), .AW(AW), .DW(DW)) u_dig (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_dig), .addr(eff_addr),
    .wdata(din_s), .mode24(mode24_o), .rdata(dig_rdata));

  nbus_ctl_regs #(.DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sel_hi_s(sel_hi_s),
    .wr_d(wr_d), .wr_e(wr_e), .wr_f(wr_f), .wdata(din_s),
    .busy_i(busy_i), .irq_set_i(irq_set_i), .adj_done_i(adj_done_i),
    .reg_d(reg_d), .reg_e(reg_e), .reg_f(reg_f),
    .hold_o(hold_o), .rest_o(rest_o), .stop_o(stop_o), .mode24_o(mode24_o),
    .test_o(test_o), .mask_o(mask_o), .irq_mode_o(irq_mode_o),
    .tsel_o(tsel_o), .adj_o(adj_o), .irq_o(irq_o));

  always_comb begin
    case (eff_addr)
      A_CTLD:  rdata = reg_d;
      A_CTLE:  rdata = reg_e;
      A_CTLF:  rdata = reg_f;
      default: rdata = dig_rdata;
    endcase
  end

  assign doe  = rd_live;
  assign dout = rd_live ? rdata : '0;

  AST_NO_READ_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_s && !wr_s) |-> !doe); // R5
  AST_NO_WRITE_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hi_s |=> $stable(reg_e) && $stable(reg_f[3:1])); // R6
endmodule

// File: tb/sim_nbus_regif.sv
`timescale 1ns/1ps
module sim_nbus_regif;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b0, sel_hi = 1'b1, ale = 1'b1;
  logic [3:0] addr_in = '0, din = '0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic busy_i = 1'b0, irq_set_i = 1'b0, adj_done_i = 1'b0;
  logic [3:0] dout;
  logic doe, hold_o, rest_o, stop_o, mode24_o, test_o, mask_o, irq_mode_o, adj_o, irq_o;
  logic [1:0] tsel_o;

  always #2.5 clk = ~clk;

  nbus_regif u0 (.*);

  typedef struct { string tag; int kind; logic [10:0] msk; logic [10:0] exp; } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0, reported = 0;

  wire [10:0] ctlv = {irq_o, adj_o, tsel_o, irq_mode_o, mask_o, test_o,
                      mode24_o, stop_o, rest_o, hold_o};

  // Monitor: compares queued expectations mid-cycle
  initial forever begin
    @(negedge clk); #1;
    while (q.size() > 0) begin
      item_t it;
      logic [10:0] act;
      it = q.pop_front();
      n_cmp++;
      case (it.kind)
        0: act = {6'b0, doe, dout};
        1: act = {10'b0, doe};
        default: act = ctlv & it.msk;
      endcase
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input string tag, input int kind, input logic [10:0] msk, input logic [10:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.msk = msk; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [3:0] d);
    addr_in = a; din = d; cyc(4);
    wr_n = 1'b0; cyc(4);
    wr_n = 1'b1; cyc(5);
  endtask

  task automatic do_read(input string tag, input logic [3:0] e);
    rd_n = 1'b0; cyc(4);
    push(tag, 0, '0, {6'b0, 1'b1, e});
    cyc(1);
    rd_n = 1'b1; cyc(4);
  endtask

  task automatic bus_read(input string tag, input logic [3:0] a, input logic [3:0] e);
    addr_in = a;
    do_read(tag, e);
  endtask

  task automatic check_ctl(input string tag, input logic [10:0] m, input logic [10:0] e);
    push(tag, 2, m, e); cyc(1);
  endtask

  task automatic report;
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(3);
    push("reset doe R5", 1, '0, 11'd0); cyc(1);
    check_ctl("reset ctl R12", 11'h7FF, 11'h000);
    bus_read("reset F R9", 4'd15, 4'h0);

    // R1 digit read-back
    bus_write(4'd0, 4'd9);  bus_read("R1 S1", 4'd0, 4'd9);
    bus_write(4'd11, 4'd8); bus_read("R1 Y10", 4'd11, 4'd8);
    bus_write(4'd12, 4'd6); bus_read("R1 W", 4'd12, 4'd6);
    // R2 missing bits
    bus_write(4'd1, 4'hF); bus_read("R2 S10", 4'd1, 4'h7);
    bus_write(4'd7, 4'hF); bus_read("R2 D10", 4'd7, 4'h3);
    bus_write(4'd9, 4'hF); bus_read("R2 MO10", 4'd9, 4'h1);

    // R3 address latch
    bus_write(4'd3, 4'h5);
    ale = 1'b0; cyc(4); addr_in = 4'd0; cyc(4);
    do_read("R3 latched MI10", 4'h5);
    ale = 1'b1; cyc(4);
    bus_read("R3 transparent S1", 4'd0, 4'd9);

    // R4 write blocked by low-active select
    sel_n = 1'b1; cyc(4);
    bus_write(4'd0, 4'd5);
    sel_n = 1'b0; cyc(4);
    bus_read("R4 no write unselected", 4'd0, 4'd9);

    // R5 read suppressed when both strobes low
    addr_in = 4'd0; cyc(4);
    rd_n = 1'b0; wr_n = 1'b0; cyc(4);
    push("R5 both strobes low", 1, '0, 11'd0); cyc(1);
    sel_n = 1'b1; cyc(4);
    rd_n = 1'b1; wr_n = 1'b1; cyc(4);
    sel_n = 1'b0; cyc(4);
    bus_read("R5 value kept", 4'd0, 4'd9);

    // R6 high-active select forces clear and blocks writes
    bus_write(4'd15, 4'b0001);
    bus_write(4'd13, 4'b0101);
    check_ctl("R6 hold/rest set", 11'h003, 11'h003);
    sel_hi = 1'b0; cyc(4);
    bus_write(4'd0, 4'd3);
    check_ctl("R6 hold/rest forced", 11'h003, 11'h000);
    sel_hi = 1'b1; cyc(4);
    bus_read("R6 write ignored", 4'd0, 4'd9);

    // R7 busy read-only
    busy_i = 1'b1; cyc(1);
    bus_read("R7 busy seen", 4'd13, 4'b0010);
    bus_write(4'd13, 4'b0100);
    bus_read("R7 busy unchanged by write", 4'd13, 4'b0010);
    busy_i = 1'b0; cyc(1);
    bus_read("R7 busy low", 4'd13, 4'b0000);

    // R8 interrupt flag
    irq_set_i = 1'b1; cyc(1); irq_set_i = 1'b0; cyc(1);
    bus_read("R8 flag set", 4'd13, 4'b0100);
    bus_write(4'd13, 4'b0100);
    bus_read("R8 write 1 keeps", 4'd13, 4'b0100);
    bus_write(4'd13, 4'b0000);
    bus_read("R8 write 0 clears", 4'd13, 4'b0000);

    // R9 hour-format guard
    bus_write(4'd15, 4'b0100);
    bus_read("R9 mode refused", 4'd15, 4'b0000);
    bus_write(4'd15, 4'b0001);
    bus_write(4'd15, 4'b0101);
    bus_read("R9 mode accepted", 4'd15, 4'b0101);

    // R10 PM/h20 handling
    bus_write(4'd5, 4'b0110);
    bus_read("R10 PM hidden 24h", 4'd5, 4'b0010);
    bus_write(4'd15, 4'b0001);
    bus_read("R10 h20 cleared on 12h", 4'd5, 4'b0100);
    bus_write(4'd5, 4'b0110);
    bus_read("R10 h20 written", 4'd5, 4'b0110);

    // R11 adjust request
    bus_write(4'd13, 4'b1100);
    check_ctl("R11 adj set", 11'h200, 11'h200);
    bus_read("R11 adj readback", 4'd13, 4'b1000);
    adj_done_i = 1'b1; cyc(1); adj_done_i = 1'b0; cyc(1);
    check_ctl("R11 adj cleared", 11'h200, 11'h000);

    // R12 register E fields
    bus_write(4'd14, 4'b1011);
    check_ctl("R12 E outputs", 11'h1E0, 11'h160);
    bus_read("R12 E readback", 4'd14, 4'b1011);

    cyc(4);
    done = 1;
    report();
  end
endmodule